// File: doc/BRIEF.md
# Pipeline operand forwarding unit

This block chooses, for each of the two ALU source operands in the execute stage of a five-stage in-order pipeline, where the operand value comes from. There are three possible sources. The first is the value read from the register file. The second is the result held in the execute/memory pipeline register. The third is the result held in the memory/writeback pipeline register. Forwarding lets a dependent instruction use a result as soon as it has been computed, without waiting for it to reach the register file.

The execute stage carries the two source register numbers that came down the pipeline from decode. Each source number is compared with the destination number of the instruction one stage ahead and with the destination number of the instruction two stages ahead. A comparison only counts when that producing instruction writes a register. When both older stages hold a matching producer, the younger one (execute/memory) holds the most recent value and wins. A parameter makes register 0 a hard-wired zero that is never forwarded.

The selects are purely combinational. They drive the operand multiplexers, which are outside this block.

Top module: `fwd_select`

## Requirements
- R1: When neither older stage holds a writing producer whose destination equals the operand's source number, that operand's select is 2'b00 (register file value).
- R2: When the execute/memory stage writes a register and its destination equals the operand's source number, the select is 2'b10 (execute/memory result).
- R3: When the memory/writeback stage writes a register and its destination equals the operand's source number, and the condition of R2 does not hold, the select is 2'b01 (memory/writeback result).
- R4: When both older stages match the same source number with their write flags set, the select is 2'b10. The younger result wins.
- R5: A stage whose write flag is low has no effect on either select, whatever its destination number is.
- R6: With ZERO_REG set to 1, which is the default, a source number of 0 always gives select 2'b00. With ZERO_REG set to 0, register 0 forwards like any other register.
- R7: Operand A's select depends only on its own source number, and operand B's select depends only on its own source number. The two operands can take different selects in the same cycle.
- R8: A select never takes the value 2'b11.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| ex_src_a | input | REG_W | First source register number held in the decode/execute register |
| ex_src_b | input | REG_W | Second source register number held in the decode/execute register |
| mem_dst | input | REG_W | Destination register number in the execute/memory register |
| mem_we | input | 1 | Register write flag of the execute/memory instruction |
| wb_dst | input | REG_W | Destination register number in the memory/writeback register |
| wb_we | input | 1 | Register write flag of the memory/writeback instruction |
| sel_a | output | 2 | Operand A source: 00 register file, 10 execute/memory, 01 memory/writeback |
| sel_b | output | 2 | Operand B source, encoded the same way as sel_a |

## Verification
The assertions assume that all inputs are known, two-state values that are settled when the checks evaluate. They do not assume anything about how register numbers relate to one another. Equal destinations in both stages and matches with the write flag low are both legal. The stimulus changes every input just after a clock edge and samples at the falling edge. It draws register numbers from a narrow range, so that matches, double matches and register 0 occur often. Directed cases come first and cover each priority and gating corner.

// File: rtl/fwd_select.sv
module fwd_select #(
  parameter int REG_W    = 4,
  parameter bit ZERO_REG = 1'b1
) (
  input  logic [REG_W-1:0] ex_src_a,
  input  logic [REG_W-1:0] ex_src_b,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_we,
  input  logic [REG_W-1:0] wb_dst,
  input  logic             wb_we,
  output logic [1:0]       sel_a,
  output logic [1:0]       sel_b
);
  localparam logic [1:0] SEL_RF  = 2'b00;
  localparam logic [1:0] SEL_MEM = 2'b10;
  localparam logic [1:0] SEL_WB  = 2'b01;

  logic [1:0][REG_W-1:0] src;
  logic [1:0][1:0]       sel;

  assign src[0] = ex_src_a;
  assign src[1] = ex_src_b;

  for (genvar i = 0; i < 2; i++) begin : g_opnd
    logic live, hit_mem, hit_wb;
    assign live    = !(ZERO_REG && src[i] == '0);
    assign hit_mem = live && mem_we && (mem_dst == src[i]);
    assign hit_wb  = live && wb_we && (wb_dst == src[i]);
    assign sel[i]  = hit_mem ? SEL_MEM : (hit_wb ? SEL_WB : SEL_RF);
  end

  assign sel_a = sel[0];
  assign sel_b = sel[1];
endmodule

// File: rtl/fwd_select_chk.sv
module fwd_select_chk #(
  parameter int REG_W    = 4,
  parameter bit ZERO_REG = 1'b1
) (
  input logic [REG_W-1:0] ex_src_a,
  input logic [REG_W-1:0] ex_src_b,
  input logic [REG_W-1:0] mem_dst,
  input logic             mem_we,
  input logic [REG_W-1:0] wb_dst,
  input logic             wb_we,
  input logic [1:0]       sel_a,
  input logic [1:0]       sel_b
);
  always_comb begin
    a_r8_no_code3: assert (sel_a != 2'b11 && sel_b != 2'b11);
    if (!mem_we) a_r5_mem_gated: assert (sel_a != 2'b10 && sel_b != 2'b10);
    if (!wb_we)  a_r5_wb_gated:  assert (sel_a != 2'b01 && sel_b != 2'b01);
    if (ZERO_REG && ex_src_a == '0) a_r6_zero_a: assert (sel_a == 2'b00);
    if (ZERO_REG && ex_src_b == '0) a_r6_zero_b: assert (sel_b == 2'b00);
    if (sel_a == 2'b10) a_r2_mem_a: assert (mem_dst == ex_src_a);
    if (sel_b == 2'b10) a_r2_mem_b: assert (mem_dst == ex_src_b);
    if (sel_a == 2'b01) a_r3_wb_a: assert (wb_dst == ex_src_a && !(mem_we && mem_dst == ex_src_a));
    if (sel_b == 2'b01) a_r3_wb_b: assert (wb_dst == ex_src_b && !(mem_we && mem_dst == ex_src_b));
    if (ex_src_a == ex_src_b) a_r7_same_src: assert (sel_a == sel_b);
  end
endmodule

bind fwd_select fwd_select_chk #(.REG_W(REG_W), .ZERO_REG(ZERO_REG)) u_chk (.*);

// File: tb/fwd_select_bench.sv
module fwd_select_bench;
  localparam int W = 4;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [W-1:0] sa, sb, md, wd;
  logic mw, ww;
  logic [1:0] sel_a, sel_b, nz_a, nz_b;
  int compared = 0, mismatched = 0;

  fwd_select u_fwd_select (.ex_src_a(sa), .ex_src_b(sb), .mem_dst(md), .mem_we(mw),
    .wb_dst(wd), .wb_we(ww), .sel_a(sel_a), .sel_b(sel_b));
  fwd_select #(.REG_W(W), .ZERO_REG(1'b0)) u_fwd_select_nz (.ex_src_a(sa), .ex_src_b(sb),
    .mem_dst(md), .mem_we(mw), .wb_dst(wd), .wb_we(ww), .sel_a(nz_a), .sel_b(nz_b));

  function automatic logic [1:0] model(int s, int m, bit mwe, int w, bit wwe, bit zr);
    int best = 0;
    if (zr && s == 0) return 2'b00;
    if (wwe && w == s) best = 1;
    if (mwe && m == s) best = 2;
    case (best)
      2: return 2'b10;
      1: return 2'b01;
      default: return 2'b00;
    endcase
  endfunction

  task automatic cmp(string tag, logic [1:0] got, logic [1:0] exp);
    compared++;
    if (got !== exp) begin
      mismatched++;
      $display("FAIL %s: got %b expected %b (a=%0d b=%0d m=%0d/%0b w=%0d/%0b)",
               tag, got, exp, sa, sb, md, mw, wd, ww);
    end
  endtask

  task automatic step(string tag, int a, int b, int m, bit mwe, int w, bit wwe);
    @(posedge clk); #1;
    sa = W'(a); sb = W'(b); md = W'(m); mw = mwe; wd = W'(w); ww = wwe;
    @(negedge clk);
    cmp({tag, " A"}, sel_a, model(a, m, mwe, w, wwe, 1'b1));
    cmp({tag, " B"}, sel_b, model(b, m, mwe, w, wwe, 1'b1));
    cmp({tag, " A nz"}, nz_a, model(a, m, mwe, w, wwe, 1'b0));
    cmp({tag, " B nz"}, nz_b, model(b, m, mwe, w, wwe, 1'b0));
  endtask

  initial begin
    #100000;
    mismatched++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    sa = '0; sb = '0; md = '0; wd = '0; mw = 1'b0; ww = 1'b0;
    @(negedge clk);
    cmp("R1 idle A", sel_a, 2'b00);
    cmp("R1 idle B", sel_b, 2'b00);
    step("R1 no match", 3, 4, 5, 1, 6, 1);
    step("R2 mem hit A", 3, 4, 3, 1, 6, 1);
    step("R3 wb hit B", 3, 4, 5, 1, 4, 1);
    step("R4 both hit", 7, 7, 7, 1, 7, 1);
    step("R5 mem we low", 3, 4, 3, 0, 3, 0);
    step("R5 wb only", 3, 4, 3, 0, 3, 1);
    step("R6 zero src", 0, 0, 0, 1, 0, 1);
    step("R6 zero wb", 0, 2, 9, 1, 0, 1);
    step("R7 split", 8, 9, 8, 1, 9, 1);
    step("R7 split rev", 8, 9, 9, 1, 8, 1);
    step("R8 max reg", 15, 15, 15, 1, 14, 1);
    for (int i = 0; i < 3000; i++)
      step("R8 rand", $urandom_range(0, 3), $urandom_range(0, 3), $urandom_range(0, 3),
           1'($urandom), $urandom_range(0, 3), 1'($urandom));
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule